// File: doc/BRIEF.md
# Card Bus Clock Divider and Gate

This block drives the bus clock of a MultiMedia Card host. A free-running system clock is divided by a value that software sets, and the result goes to the card. The same logic decides when that clock may be stopped, either to save power or to slow the data flow. A card needs eight more clock cycles after the final bit of a bus exchange. For that reason a stop request is only acted on once those trailing cycles have been sent.

The neighbouring command and data controllers report the end of each exchange with a one-cycle strobe. The four strobes are:
- the end bit of a command that expects no response;
- the end bit of the card's response;
- the end bit of the last read block;
- the CRC status token after a write.

Software supplies a stop request, a transaction-start request, a busy-release pulse request and the divider value. The block also watches the sampled data line so that it can hand a busy card the single edge the card needs to release that line.

Top module: `mmc_clk_gate`

## Requirements
- R1: During and after reset, `card_clk` is low and `clk_stopped` is high until `xfer_start` is pulsed.
- R2: While running, each high half and each low half of `card_clk` lasts D+1 system cycles, where D is the latched divider value. D = 0 gives a clock of half the system rate.
- R3: `div_val` is latched only when `card_clk` rises, or when a busy pulse starts. A change in the middle of a half leaves that half and the low half that follows it unchanged.
- R4: Each end strobe (`ev_cmd_nores`, `ev_rsp_end`, `ev_rd_end`, `ev_wr_crc`) reloads a trailing count of eight. The clock is not gated until eight full card cycles, with eight rising edges, have passed since the most recent strobe.
- R5: A `stop_req` with no trailing count outstanding gates the clock at the end of the current low half. A `stop_req` that arrives during a trailing count is held pending until the count is exhausted.
- R6: Gating only ever begins at the end of a low half. While gated, `card_clk` stays low and `clk_stopped` is high.
- R7: While gated with `dat_in` low, a `busy_pulse_req` pulse produces exactly one clock period, high half first, and the clock then returns to the gated state. `clk_stopped` is low during that period.
- R8: A `busy_pulse_req` while gated with `dat_in` high has no effect, and no edge appears on `card_clk`.
- R9: `xfer_start` restarts a gated clock, beginning with a low half, and cancels any pending stop. It takes priority over a `stop_req` in the same cycle.
- R10: A `stop_req` issued while the clock is already gated is discarded. After a later `xfer_start`, the clock runs until a new stop request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Half-period divider setting D (each half lasts D+1 cycles) |
| ev_cmd_nores | input | 1 | Strobe: end bit of a host command that expects no response |
| ev_rsp_end | input | 1 | Strobe: end bit of the card's response |
| ev_rd_end | input | 1 | Strobe: end bit of the last read block |
| ev_wr_crc | input | 1 | Strobe: CRC status token after a write |
| xfer_start | input | 1 | Strobe: a transaction is about to start; run the clock |
| stop_req | input | 1 | Strobe: stop the clock once it is allowed |
| busy_pulse_req | input | 1 | Strobe: issue one clock period to a busy card |
| dat_in | input | 1 | Sampled data line level (low means busy) |
| card_clk | output | 1 | Clock to the card |
| clk_stopped | output | 1 | High while the card clock is gated |

## Verification
The divider is tried at settings of 0, 1, 2 and 4. One of these changes happens in the middle of a high half, which separates latching at the rising edge from using the new value at once. Each of the four end strobes is followed by a stop request. The rising edges counted up to gating show whether the eight-cycle tail is honoured for every exchange type, and a second strobe sent during a running count shows that the count reloads. Busy pulses are issued with the data line low and with it high, which separates the one-period release from an ignored request. Stop and start requests that coincide, or that arrive while the clock is already gated, show which request wins.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    localparam int unsigned TRAIL_CYCLES = 8;
    localparam int unsigned TRAIL_W      = $clog2(TRAIL_CYCLES + 1);

    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_RUN  = 2'd1,
        GATE_BLIP = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic cmd_nores;
        logic rsp_end;
        logic rd_end;
        logic wr_crc;
    } end_ev_t;

    typedef struct packed {
        logic kick;
        logic hold;
        logic suppress;
    } div_ctl_t;

    typedef struct packed {
        logic phase;
        logic boundary;
    } div_stat_t;

    function automatic logic any_end(input end_ev_t e);
        return e.cmd_nores | e.rsp_end | e.rd_end | e.wr_crc;
    endfunction

endpackage

// File: rtl/mcg_divider.sv
module mcg_divider
    import mcg_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  div_ctl_t         ctl,
    input  logic [DIV_W-1:0] div_val,
    output div_stat_t        stat
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_cur_q;
    logic             phase_q;
    logic             half_done;

    assign half_done     = (cnt_q == div_cur_q);
    assign stat.phase    = phase_q;
    assign stat.boundary = !phase_q && half_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            div_cur_q <= '0;
            phase_q   <= 1'b0;
        end else if (ctl.kick) begin
            cnt_q     <= '0;
            phase_q   <= 1'b1;
            div_cur_q <= div_val;
        end else if (ctl.hold) begin
            cnt_q     <= '0;
            phase_q   <= 1'b0;
            div_cur_q <= div_val;
        end else if (half_done) begin
            cnt_q <= '0;
            if (phase_q) begin
                phase_q <= 1'b0;
            end else if (!ctl.suppress) begin
                phase_q   <= 1'b1;
                div_cur_q <= div_val;
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mcg_trail.sv
module mcg_trail
    import mcg_pkg::*;
#(
    parameter int unsigned LEN = TRAIL_CYCLES
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic idle
);

    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] left_q;

    assign idle = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= CW'(LEN);
        end else if (dec && !idle) begin
            left_q <= left_q - 1'b1;
        end
    end

endmodule

// File: rtl/mcg_gate_fsm.sv
module mcg_gate_fsm
    import mcg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer_start,
    input  logic        stop_req,
    input  logic        busy_pulse_req,
    input  logic        dat_in,
    input  logic        any_ev,
    input  logic        boundary,
    input  logic        trail_idle,
    output div_ctl_t    ctl,
    output logic        trail_load,
    output logic        trail_dec,
    output gate_state_e state
);

    gate_state_e st_q, st_d;
    logic        pend_q;
    logic        kick, stop_now, blip_end;

    always_comb begin
        kick     = (st_q == GATE_OFF) && busy_pulse_req && !dat_in && !xfer_start;
        stop_now = (st_q == GATE_RUN) && boundary && pend_q && trail_idle
                   && !xfer_start && !any_ev;
        blip_end = (st_q == GATE_BLIP) && boundary && !xfer_start && !any_ev;

        ctl.kick     = kick;
        ctl.hold     = (st_q == GATE_OFF);
        ctl.suppress = stop_now || blip_end;

        trail_load = (st_q != GATE_OFF) && any_ev;
        trail_dec  = (st_q == GATE_RUN) && boundary;

        st_d = st_q;
        if (xfer_start) begin
            st_d = GATE_RUN;
        end else begin
            unique case (st_q)
                GATE_OFF:  if (kick)     st_d = GATE_BLIP;
                GATE_RUN:  if (stop_now) st_d = GATE_OFF;
                GATE_BLIP: begin
                    if (any_ev)        st_d = GATE_RUN;
                    else if (blip_end) st_d = GATE_OFF;
                end
                default:   st_d = GATE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= GATE_OFF;
            pend_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (xfer_start || (st_q == GATE_OFF) || stop_now) begin
                pend_q <= 1'b0;
            end else if (stop_req) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign state = st_q;

endmodule

// File: rtl/mmc_clk_gate.sv
module mmc_clk_gate
    import mcg_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ev_cmd_nores,
    input  logic             ev_rsp_end,
    input  logic             ev_rd_end,
    input  logic             ev_wr_crc,
    input  logic             xfer_start,
    input  logic             stop_req,
    input  logic             busy_pulse_req,
    input  logic             dat_in,
    output logic             card_clk,
    output logic             clk_stopped
);

    end_ev_t     evs;
    div_ctl_t    dctl;
    div_stat_t   dstat;
    gate_state_e gstate;
    logic        t_load, t_dec, t_idle;

    assign evs = '{cmd_nores: ev_cmd_nores, rsp_end: ev_rsp_end,
                   rd_end: ev_rd_end, wr_crc: ev_wr_crc};

    mcg_gate_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .xfer_start     (xfer_start),
        .stop_req       (stop_req),
        .busy_pulse_req (busy_pulse_req),
        .dat_in         (dat_in),
        .any_ev         (any_end(evs)),
        .boundary       (dstat.boundary),
        .trail_idle     (t_idle),
        .ctl            (dctl),
        .trail_load     (t_load),
        .trail_dec      (t_dec),
        .state          (gstate)
    );

    mcg_trail #(.LEN(TRAIL_CYCLES)) u_trail (
        .clk  (clk),
        .rst  (rst),
        .load (t_load),
        .dec  (t_dec),
        .idle (t_idle)
    );

    mcg_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .ctl     (dctl),
        .div_val (div_val),
        .stat    (dstat)
    );

    assign card_clk    = dstat.phase;
    assign clk_stopped = (gstate == GATE_OFF);

endmodule

// File: rtl/mcg_checker.sv
module mcg_checker #(
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] div_val,
    input logic             ev_cmd_nores,
    input logic             ev_rsp_end,
    input logic             ev_rd_end,
    input logic             ev_wr_crc,
    input logic             xfer_start,
    input logic             busy_pulse_req,
    input logic             dat_in,
    input logic             card_clk,
    input logic             clk_stopped
);

    logic             prev_clk;
    logic [DIV_W-1:0] prev_div;
    logic [DIV_W:0]   hi_cnt;
    logic [DIV_W:0]   exp_half;
    logic             armed;
    logic [3:0]       rise_cnt;
    logic             ev_any;

    assign ev_any = ev_cmd_nores | ev_rsp_end | ev_rd_end | ev_wr_crc;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            prev_div <= '0;
            hi_cnt   <= '0;
            exp_half <= '0;
            armed    <= 1'b0;
            rise_cnt <= '0;
        end else begin
            prev_clk <= card_clk;
            prev_div <= div_val;
            if (card_clk && !prev_clk) begin
                hi_cnt   <= (DIV_W+1)'(1);
                exp_half <= (DIV_W+1)'(prev_div) + (DIV_W+1)'(1);
            end else if (card_clk) begin
                hi_cnt <= hi_cnt + 1'b1;
            end
            if (ev_any && !clk_stopped) begin
                armed    <= 1'b1;
                rise_cnt <= '0;
            end else begin
                if (clk_stopped) armed <= 1'b0;
                if (card_clk && !prev_clk && rise_cnt != 4'd15)
                    rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    // R2 and R3: the high half length follows the value latched at the rise
    p_half_len_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(card_clk) |-> (hi_cnt == exp_half));

    p_trailing_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_stopped) |-> (!armed || rise_cnt >= 4'd8));

    p_low_when_gated_r6: assert property (@(posedge clk) disable iff (rst)
        clk_stopped |-> !card_clk);

    p_gate_after_low_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_stopped) |-> !$past(card_clk));

    p_busy_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (clk_stopped && busy_pulse_req && !dat_in && !xfer_start)
        |=> (card_clk && !clk_stopped));

    p_busy_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (clk_stopped && dat_in && !xfer_start) |=> clk_stopped);

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (clk_stopped && xfer_start) |=> (!clk_stopped && !card_clk));

endmodule

bind mmc_clk_gate mcg_checker #(.DIV_W(DIV_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .div_val        (div_val),
    .ev_cmd_nores   (ev_cmd_nores),
    .ev_rsp_end     (ev_rsp_end),
    .ev_rd_end      (ev_rd_end),
    .ev_wr_crc      (ev_wr_crc),
    .xfer_start     (xfer_start),
    .busy_pulse_req (busy_pulse_req),
    .dat_in         (dat_in),
    .card_clk       (card_clk),
    .clk_stopped    (clk_stopped)
);

// File: tb/test_mmc_clk_gate.sv
`timescale 1ns/100ps
module test_mmc_clk_gate;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] div_val = 8'd2;
    logic          ev_cmd_nores = 0, ev_rsp_end = 0, ev_rd_end = 0, ev_wr_crc = 0;
    logic          xfer_start = 0, stop_req = 0, busy_pulse_req = 0, dat_in = 1;
    logic          card_clk, clk_stopped;

    always #2.5 clk = ~clk;

    mmc_clk_gate #(.DIV_W(DW)) i_mmc_clk_gate (
        .clk(clk), .rst(rst), .div_val(div_val),
        .ev_cmd_nores(ev_cmd_nores), .ev_rsp_end(ev_rsp_end),
        .ev_rd_end(ev_rd_end), .ev_wr_crc(ev_wr_crc),
        .xfer_start(xfer_start), .stop_req(stop_req),
        .busy_pulse_req(busy_pulse_req), .dat_in(dat_in),
        .card_clk(card_clk), .clk_stopped(clk_stopped)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    int rises = 0;
    bit last_clk = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 gated, 1 running, 2 single busy period
    int m_st = 0, m_cnt = 0, m_ph = 0, m_div = 0, m_trail = 0, m_pend = 0;

    always @(posedge clk) begin : model
        bit ev, bnd, kick, stopnow, bend, sup;
        int nst;
        if (card_clk && !last_clk) rises++;
        last_clk = card_clk;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_ph = 0; m_div = 0; m_trail = 0; m_pend = 0;
        end else begin
            ev      = ev_cmd_nores | ev_rsp_end | ev_rd_end | ev_wr_crc;
            bnd     = (m_ph == 0) && (m_cnt == m_div);
            kick    = (m_st == 0) && busy_pulse_req && !dat_in && !xfer_start;
            stopnow = (m_st == 1) && bnd && (m_pend != 0) && (m_trail == 0) && !xfer_start && !ev;
            bend    = (m_st == 2) && bnd && !xfer_start && !ev;
            sup     = stopnow || bend;
            if (m_st != 0 && ev) m_trail = 8;
            else if (m_st == 1 && bnd && m_trail > 0) m_trail = m_trail - 1;
            if (xfer_start || m_st == 0 || stopnow) m_pend = 0;
            else if (stop_req) m_pend = 1;
            if (kick) begin m_ph = 1; m_cnt = 0; m_div = int'(div_val); end
            else if (m_st == 0) begin m_ph = 0; m_cnt = 0; m_div = int'(div_val); end
            else if (m_cnt == m_div) begin
                m_cnt = 0;
                if (m_ph == 1) m_ph = 0;
                else if (!sup) begin m_ph = 1; m_div = int'(div_val); end
            end else m_cnt = m_cnt + 1;
            if (xfer_start) nst = 1;
            else if (m_st == 0) nst = kick ? 2 : 0;
            else if (m_st == 1) nst = stopnow ? 0 : 1;
            else nst = ev ? 1 : (bend ? 0 : 2);
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(card_clk == m_ph[0], "R2 card_clk vs model", int'(card_clk), m_ph);
            check(clk_stopped == (m_st == 0), "R6 clk_stopped vs model",
                  int'(clk_stopped), int'(m_st == 0));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // 0..3 end strobes, 4 start, 5 stop, 6 busy pulse, 7 start+stop together
    task automatic fire(input int which);
        @(negedge clk);
        case (which)
            0: ev_cmd_nores = 1;
            1: ev_rsp_end = 1;
            2: ev_rd_end = 1;
            3: ev_wr_crc = 1;
            4: xfer_start = 1;
            5: stop_req = 1;
            6: busy_pulse_req = 1;
            default: begin xfer_start = 1; stop_req = 1; end
        endcase
        @(negedge clk);
        {ev_cmd_nores, ev_rsp_end, ev_rd_end, ev_wr_crc} = '0;
        {xfer_start, stop_req, busy_pulse_req} = '0;
    endtask

    task automatic wait_level(input bit lvl);
        int g = 0;
        while (card_clk != lvl && g < 400) begin @(negedge clk); g++; end
    endtask

    task automatic run_len(input bit lvl, output int n);
        n = 0;
        while (card_clk == lvl && n < 400) begin n++; @(negedge clk); end
    endtask

    task automatic wait_stopped;
        int g = 0;
        while (!clk_stopped && g < 400) begin @(negedge clk); g++; end
    endtask

    initial begin
        int n, r0;
        tick(4);
        check(card_clk == 0, "R1 clock low in reset", int'(card_clk), 0);
        check(clk_stopped == 1, "R1 stopped in reset", int'(clk_stopped), 1);
        rst = 0;
        tick(5);
        check(clk_stopped == 1 && rises == 0, "R1 stays gated", rises, 0);

        // R2: divider 2
        fire(4);
        wait_level(1); run_len(1, n);
        check(n == 3, "R2 high half D=2", n, 3);
        run_len(0, n);
        check(n == 3, "R2 low half D=2", n, 3);

        // R3: change divider inside a high half
        wait_level(1);
        div_val = 8'd4;
        run_len(1, n);
        check(n == 3, "R3 current high half kept", n, 3);
        run_len(0, n);
        check(n == 3, "R3 following low half kept", n, 3);
        run_len(1, n);
        check(n == 5, "R3 new value at next rise", n, 5);

        // R5: stop with no tail outstanding
        div_val = 8'd1;
        fire(5);
        wait_stopped();
        check(clk_stopped == 1, "R5 gated after stop", int'(clk_stopped), 1);
        r0 = rises;
        tick(12);
        check(card_clk == 0 && rises == r0, "R6 no edges while gated", rises - r0, 0);

        // R4: each end strobe type
        for (int k = 0; k < 4; k++) begin
            fire(4);
            tick(5);
            fire(k);
            r0 = rises;
            fire(5);
            wait_stopped();
            tick(2);
            check((rises - r0) >= 8 && (rises - r0) <= 9, "R4 tail rises per strobe",
                  rises - r0, 8);
        end

        // R4: a second strobe during the tail restarts it
        fire(4);
        fire(1);
        tick(14);
        fire(5);
        fire(3);
        r0 = rises;
        wait_stopped();
        tick(2);
        check((rises - r0) >= 8 && (rises - r0) <= 9, "R4 retriggered tail", rises - r0, 8);

        // R7: busy pulse with data line low
        dat_in = 0;
        r0 = rises;
        fire(6);
        check(card_clk == 1 && clk_stopped == 0, "R7 pulse starts high",
              int'(card_clk), 1);
        wait_stopped();
        tick(3);
        check(rises - r0 == 1, "R7 exactly one period", rises - r0, 1);

        // R8: busy pulse with data line high
        dat_in = 1;
        r0 = rises;
        fire(6);
        tick(20);
        check(clk_stopped == 1 && rises == r0, "R8 request ignored", rises - r0, 0);

        // R9: start and stop together, then a pending stop cancelled
        fire(7);
        tick(60);
        check(clk_stopped == 0, "R9 start wins over stop", int'(clk_stopped), 0);
        fire(0);
        fire(5);
        fire(4);
        tick(60);
        check(clk_stopped == 0, "R9 pending stop cancelled", int'(clk_stopped), 0);
        fire(5);
        wait_stopped();
        check(clk_stopped == 1, "R5 stop after cancel", int'(clk_stopped), 1);

        // R10: stop while gated is discarded
        fire(5);
        tick(5);
        fire(4);
        r0 = rises;
        tick(80);
        check(clk_stopped == 0 && (rises - r0) >= 15, "R10 clock keeps running",
              rises - r0, 20);

        // R2: divider 0
        div_val = 8'd0;
        tick(8);
        wait_level(1); run_len(1, n);
        check(n == 1, "R2 high half D=0", n, 1);
        run_len(0, n);
        check(n == 1, "R2 low half D=0", n, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule